// File: doc/BRIEF.md
# In-Order Memory Operation Queue

This block sits between an address-computing execution unit and a data memory. The unit hands over one memory operation at a time. Each operation carries an address, a direction flag, the data to store and a destination tag. The block holds a small number of these operations and sends them to memory one by one, always oldest first. So the execution unit can keep issuing loads and stores back to back while earlier operations wait for the memory.

One cycle after the memory accepts an operation, the block drives a completion beat on its writeback outputs. The beat carries the operation's tag and a flag that tells a load from a store. For a load it also carries the word the memory returned. For a store the data field is zero, and the tag alone lets the owner of the entry mark it complete. The memory model is a plain synchronous RAM: it grants an access with `mem_gnt` and returns read data on the cycle after the grant.

Top module: `mem_order_queue`

## Requirements
- R1: While reset is held and right after it, `enq_ready` is 1, `mem_req` is 0 and `wb_valid` is 0.
- R2: With `mem_gnt` held at 0, exactly DEPTH (4) operations are accepted. `enq_ready` then stays 0 as long as the memory keeps refusing.
- R3: When the queue is full and the memory grants the oldest entry in the same cycle, `enq_ready` is 1 and a new operation is taken in that cycle. The queue stays full afterwards.
- R4: Operations reach the memory in exactly the order they were accepted, each one exactly once.
- R5: `mem_req` is 1 whenever at least one operation is held. `mem_addr` and `mem_wdata` come from the oldest entry. `mem_we` is 1 for a store (`enq_is_read`=0) and 0 for a load (`enq_is_read`=1).
- R6: Each granted access produces exactly one `wb_valid` pulse, in the cycle after the grant, carrying that operation's tag. No other cycle has `wb_valid` set.
- R7: For a load, the writeback has `wb_is_load`=1 and `wb_data` equals the memory word at that address, including a store accepted just before it.
- R8: For a store, the writeback has `wb_is_load`=0 and `wb_data`=0.
- R9: While `mem_req` is 1 and `mem_gnt` is 0, `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R10: An operation offered while `enq_ready` is 0 and withdrawn before acceptance never reaches the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | An operation is offered |
| enq_ready | output | 1 | The offered operation is taken this cycle |
| enq_addr | input | ADDR_W (16) | Memory word address |
| enq_is_read | input | 1 | 1 = load, 0 = store |
| enq_wdata | input | DATA_W (16) | Data to store |
| enq_tag | input | TAG_W (5) | Destination tag |
| mem_req | output | 1 | Oldest operation requests memory |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | 1 = write access |
| mem_addr | output | ADDR_W (16) | Access address |
| mem_wdata | output | DATA_W (16) | Write data |
| mem_rdata | input | DATA_W (16) | Read data, valid the cycle after a granted read |
| wb_valid | output | 1 | Completion beat |
| wb_is_load | output | 1 | Completion belongs to a load |
| wb_tag | output | TAG_W (5) | Tag of the completed operation |
| wb_data | output | DATA_W (16) | Loaded word, zero for stores |

## Verification
The embedded properties check, on every cycle, the rules that do not depend on history. They cover the one-cycle link from a grant to its writeback tag and load flag, the frozen request during a stall, the fact that a refused offer only occurs while the memory is busy, and the absence of overflow or underflow in the storage. The bench scenarios cover what only a reference model can judge: arrival order across many operations, load values after a store to the same address, zero data on store completions, the exact capacity, the swap when the queue is full, and offers that are dropped without reaching memory.

// File: rtl/mq_pkg.sv
package mq_pkg;
   typedef enum logic {
      MQ_WRITE = 1'b0,
      MQ_READ  = 1'b1
   } mq_dir_e;
endpackage

// File: rtl/mq_fifo.sv
module mq_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   initial begin
      assert (DEPTH >= 2) else $error("mq_fifo: DEPTH must be at least 2");
      assert (WIDTH >= 1) else $error("mq_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] slot [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0] count;

   // Pointer advance: free wrap for power-of-two depths, explicit wrap otherwise.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_mod
         assign wr_nxt = (wr_ptr == PTR_LAST) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_LAST) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push) slot[wr_ptr] <= din;
   end

   assign dout  = slot[rd_ptr];
   assign empty = (count == '0);
   assign full  = (count == CNT_FULL);

   // R2: storage never written past capacity
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop));
   p_count_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_FULL);
   // R5: only a held entry is ever sent to memory
   p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/mq_wb_stage.sv
module mq_wb_stage #(
   parameter int TAG_W  = 5,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic              issue_load,
   input  logic [TAG_W-1:0]  issue_tag,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wb_valid,
   output logic              wb_is_load,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [DATA_W-1:0] wb_data
);
   initial begin
      assert (TAG_W >= 1) else $error("mq_wb_stage: TAG_W must be positive");
      assert (DATA_W >= 1) else $error("mq_wb_stage: DATA_W must be positive");
   end

   logic              pend_v;
   logic              pend_load;
   logic [TAG_W-1:0]  pend_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_load <= 1'b0;
         pend_tag  <= '0;
      end else begin
         pend_v <= issue;
         if (issue) begin
            pend_load <= issue_load;
            pend_tag  <= issue_tag;
         end
      end
   end

   assign wb_valid   = pend_v;
   assign wb_is_load = pend_v & pend_load;
   assign wb_tag     = pend_tag;
   assign wb_data    = (pend_v && pend_load) ? mem_rdata : '0;
endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
   import mq_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int TAG_W  = 5,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enq_valid,
   output logic              enq_ready,
   input  logic [ADDR_W-1:0] enq_addr,
   input  logic              enq_is_read,
   input  logic [DATA_W-1:0] enq_wdata,
   input  logic [TAG_W-1:0]  enq_tag,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wb_valid,
   output logic              wb_is_load,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [DATA_W-1:0] wb_data
);
   localparam int DATA_LSB = ADDR_W;
   localparam int DIR_BIT  = ADDR_W + DATA_W;
   localparam int TAG_LSB  = DIR_BIT + 1;
   localparam int ENTRY_W  = TAG_LSB + TAG_W;

   initial begin
      assert (ADDR_W >= 1) else $error("mem_order_queue: ADDR_W must be positive");
      assert (DEPTH >= 2)  else $error("mem_order_queue: DEPTH must be at least 2");
   end

   logic [ENTRY_W-1:0] in_entry, head;
   logic               q_empty, q_full;
   logic               issue, push;
   mq_dir_e            head_dir;
   logic [TAG_W-1:0]   head_tag;

   assign in_entry = {enq_tag, enq_is_read, enq_wdata, enq_addr};

   assign issue     = !q_empty && mem_gnt;
   assign enq_ready = !q_full || issue;
   assign push      = enq_valid && enq_ready;

   mq_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (issue),
      .din   (in_entry),
      .dout  (head),
      .empty (q_empty),
      .full  (q_full)
   );

   assign head_dir  = mq_dir_e'(head[DIR_BIT]);
   assign head_tag  = head[TAG_LSB +: TAG_W];
   assign mem_req   = !q_empty;
   assign mem_we    = (head_dir == MQ_WRITE);
   assign mem_addr  = head[ADDR_W-1:0];
   assign mem_wdata = head[DATA_LSB +: DATA_W];

   mq_wb_stage #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wb (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_load (head_dir == MQ_READ),
      .issue_tag  (head_tag),
      .mem_rdata  (mem_rdata),
      .wb_valid   (wb_valid),
      .wb_is_load (wb_is_load),
      .wb_tag     (wb_tag),
      .wb_data    (wb_data)
   );

   // R2: a refused offer only happens while memory holds back the head
   p_refuse_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !enq_ready |-> (mem_req && !mem_gnt));
   // R5: an accepted operation is requested on the next cycle
   p_accept_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready) |=> mem_req);
   // R6: grant is followed by a writeback with the granted tag
   p_wb_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (wb_valid && wb_tag == $past(head_tag)));
   p_wb_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_req && mem_gnt) |=> !wb_valid);
   // R7: writeback kind follows the granted access direction
   p_wb_kind_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt) |=> (wb_is_load == !$past(mem_we)));
   // R9: a stalled request is held unchanged
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)
                                 && $stable(mem_we) && $stable(mem_wdata)));
endmodule

// File: tb/tb_mem_order_queue.sv
module tb_mem_order_queue;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        enq_valid, enq_ready, enq_is_read;
   logic [15:0] enq_addr, enq_wdata;
   logic [4:0]  enq_tag;
   logic        mem_req, mem_gnt, mem_we;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        wb_valid, wb_is_load;
   logic [4:0]  wb_tag;
   logic [15:0] wb_data;

   always #5 clk = ~clk;

   mem_order_queue dut (
      .clk(clk), .rst_n(rst_n),
      .enq_valid(enq_valid), .enq_ready(enq_ready), .enq_addr(enq_addr),
      .enq_is_read(enq_is_read), .enq_wdata(enq_wdata), .enq_tag(enq_tag),
      .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .wb_valid(wb_valid), .wb_is_load(wb_is_load), .wb_tag(wb_tag),
      .wb_data(wb_data)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   // grant source: 0 always grant, 1 never, 2 irregular pattern
   int         gnt_sel = 0;
   logic [2:0] pat     = 3'b101;
   assign mem_gnt = (gnt_sel == 0) ? 1'b1 : (gnt_sel == 1) ? 1'b0 : (pat[0] ^ pat[2]);

   logic [15:0] ram    [256];
   logic [15:0] shadow [256];
   logic [15:0] rdata_q;
   assign mem_rdata = rdata_q;

   logic [15:0] exp_addr [64];
   logic        exp_rd   [64];
   logic [15:0] exp_wd   [64];
   logic [4:0]  exp_tag  [64];
   logic [15:0] exp_res  [64];
   int          acc_cyc  [64];
   int n_exp = 0, acc_idx = 0, wb_idx = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      pat <= {pat[1:0], pat[2] ^ pat[1]};
      if (mem_req && mem_gnt) begin
         if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
         rdata_q <= ram[mem_addr[7:0]];
      end
   end

   // access and writeback monitor against the in-order reference
   always @(posedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_gnt) begin
            if (acc_idx >= n_exp) begin
               chk(1'b0, "R10", "access with no accepted operation", acc_idx, n_exp);
            end else begin
               chk(mem_addr == exp_addr[acc_idx], "R4", "access address", mem_addr, exp_addr[acc_idx]);
               chk(mem_we == !exp_rd[acc_idx], "R5", "mem_we", mem_we, !exp_rd[acc_idx]);
               if (!exp_rd[acc_idx])
                  chk(mem_wdata == exp_wd[acc_idx], "R5", "store data", mem_wdata, exp_wd[acc_idx]);
               acc_cyc[acc_idx] = cyc;
            end
            acc_idx++;
         end
         if (wb_valid) begin
            if (wb_idx >= acc_idx || wb_idx >= n_exp) begin
               chk(1'b0, "R6", "writeback with no access", wb_idx, acc_idx);
            end else begin
               chk(wb_tag == exp_tag[wb_idx], "R6", "writeback tag", wb_tag, exp_tag[wb_idx]);
               chk(cyc == acc_cyc[wb_idx] + 1, "R6", "writeback cycle", cyc, acc_cyc[wb_idx] + 1);
               chk(wb_is_load == exp_rd[wb_idx], "R7", "load flag", wb_is_load, exp_rd[wb_idx]);
               if (exp_rd[wb_idx])
                  chk(wb_data == exp_res[wb_idx], "R7", "load data", wb_data, exp_res[wb_idx]);
               else
                  chk(wb_data == 16'h0, "R8", "store writeback data", wb_data, 0);
            end
            wb_idx++;
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 5000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 5000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic push(input logic [15:0] a, input logic rd,
                       input logic [15:0] d, input logic [4:0] tg);
      enq_valid = 1'b1; enq_addr = a; enq_is_read = rd; enq_wdata = d; enq_tag = tg;
      #1;
      while (!enq_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      exp_addr[n_exp] = a; exp_rd[n_exp] = rd; exp_wd[n_exp] = d; exp_tag[n_exp] = tg;
      if (rd) exp_res[n_exp] = shadow[a[7:0]];
      else begin
         shadow[a[7:0]] = d;
         exp_res[n_exp] = 16'h0;
      end
      n_exp++;
      @(negedge clk);
      enq_valid = 1'b0;
   endtask

   task automatic drain();
      gnt_sel = 0;
      for (int k = 0; k < 60 && (acc_idx < n_exp || wb_idx < n_exp); k++) @(negedge clk);
      @(negedge clk);
      chk(acc_idx == n_exp, "R4", "accesses after drain", acc_idx, n_exp);
      chk(wb_idx == n_exp, "R6", "writebacks after drain", wb_idx, n_exp);
      chk(mem_req == 1'b0, "R5", "mem_req when empty", mem_req, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; enq_valid = 1'b0; enq_addr = '0; enq_is_read = 1'b0;
      enq_wdata = '0; enq_tag = '0; gnt_sel = 0;
      repeat (3) @(negedge clk);
      chk(enq_ready == 1'b1, "R1", "enq_ready in reset", enq_ready, 1);
      chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
      chk(wb_valid == 1'b0, "R1", "wb_valid in reset", wb_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(enq_ready == 1'b1 && mem_req == 1'b0 && wb_valid == 1'b0, "R1",
          "idle after reset", {enq_ready, mem_req, wb_valid}, 3'b100);
   endtask

   task automatic t_basic();
      gnt_sel = 0;
      push(16'h0020, 1'b0, 16'hBEEF, 5'd3);  // store
      push(16'h0020, 1'b1, 16'h0000, 5'd5);  // load sees the store (R7)
      push(16'h0021, 1'b1, 16'h0000, 5'd6);  // load of untouched word
      push(16'h0021, 1'b0, 16'h1234, 5'd7);  // store, zero writeback data (R8)
      drain();
   endtask

   task automatic t_fill_stall();
      logic [15:0] held;
      gnt_sel = 1;
      for (int k = 0; k < 4; k++) push(16'h0010 + 16'(k), k[0], 16'h5A00 + 16'(k), 5'(10 + k));
      #1;
      chk(enq_ready == 1'b0, "R2", "ready after four held", enq_ready, 0);
      chk(mem_req == 1'b1, "R5", "request while held", mem_req, 1);
      chk(mem_addr == 16'h0010, "R4", "oldest at head", mem_addr, 16'h0010);
      held = mem_addr;
      // offer a fifth operation while refused, then withdraw it (R10)
      enq_valid = 1'b1; enq_addr = 16'h0077; enq_is_read = 1'b0;
      enq_wdata = 16'hDEAD; enq_tag = 5'd31;
      repeat (3) @(negedge clk);
      chk(enq_ready == 1'b0, "R2", "still refused", enq_ready, 0);
      chk(mem_addr == held && mem_we == 1'b1 && mem_wdata == 16'h5A00, "R9",
          "stalled head held", mem_addr, held);
      enq_valid = 1'b0;
      drain();
      chk(ram[8'h77] == 16'h0, "R10", "refused store absent", ram[8'h77], 0);
   endtask

   task automatic t_full_swap();
      gnt_sel = 1;
      for (int k = 0; k < 4; k++) push(16'h0030 + 16'(k), 1'b0, 16'h7700 + 16'(k), 5'(20 + k));
      #1;
      chk(enq_ready == 1'b0, "R3", "full before swap", enq_ready, 0);
      gnt_sel = 0;
      #1;
      chk(enq_ready == 1'b1, "R3", "ready on grant when full", enq_ready, 1);
      push(16'h0030, 1'b1, 16'h0000, 5'd24);
      gnt_sel = 1;
      #1;
      chk(enq_ready == 1'b0, "R3", "still full after swap", enq_ready, 0);
      drain();
   endtask

   task automatic t_mixed();
      gnt_sel = 2;
      for (int k = 0; k < 14; k++)
         push(16'h0040 + 16'(k % 3), k[0] ^ k[2], 16'h1000 + 16'(k * 37), 5'(k));
      drain();
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         ram[i] = 16'h0;
         shadow[i] = 16'h0;
      end
      rdata_q = 16'h0;
      t_reset();
      t_basic();
      t_fill_stall();
      t_full_swap();
      t_mixed();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule